// File: doc/BRIEF.md
# Reference Qualification Timer

This block decides whether one timing reference may be trusted. It watches a disruption flag from the fast reference monitors (single-period and short-window frequency checks) and a slower out-of-range flag from the precise frequency monitor. Whenever disruption is present it raises a holdover request in the same cycle, so the loop can stop following the reference at once.

Qualification moves more slowly than the holdover request. Each tick of a tick-enable input that sees disruption adds one to an accumulator. The accumulator is not cleared by a clean gap. Once the accumulated total reaches a parameter limit, the reference is disqualified. A disqualified reference is requalified only after a second, longer run of consecutive clean ticks, and requalifying clears the accumulator. Both limits are counted in ticks, so the same logic can run on a real seconds-scale timebase or on a short scaled one.

The fail output combines every monitor verdict with the timer's own verdict. It is high when there is disruption, when the reference is out of range, or when the reference is disqualified.

Top module: `ref_qual_timer`

## Requirements
- R1: `holdover_req` equals `disrupt` in the same cycle, combinationally, whatever `tick_en` and `freq_oor` are.
- R2: `freq_oor` raises `fail` in the same cycle. It has no effect on `holdover_req` and no effect on when `qualified` changes.
- R3: `fail` is high exactly when `disrupt` is high, or `freq_oor` is high, or `qualified` is low.
- R4: While qualified, every clock edge with `tick_en` and `disrupt` both high adds one to an accumulator. At the edge where the accumulated total reaches `DISQ_TICKS`, `qualified` goes low.
- R5: Disrupted ticks from separate bursts add together. While qualified, clean ticks never clear the accumulator, however many there are.
- R6: While disqualified, `qualified` goes high at the edge that samples the `REQ_TICKS`-th consecutive tick with `disrupt` low.
- R7: While disqualified, any clock edge with `disrupt` high restarts the clean run from zero, whether or not it is a tick edge.
- R8: Requalification clears the accumulator, so `DISQ_TICKS` fresh disrupted ticks are needed for the next disqualification.
- R9: While `rst_n` is low, and after it is released, the reference is disqualified (`qualified`=0, `fail`=1) with both counts at zero.
- R10: `qualified` changes only at an edge where `tick_en` is high. Edges with `disrupt` high but `tick_en` low add nothing to the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle timebase tick; both limits are counted in these |
| disrupt | input | 1 | Disruption flag from the fast monitors |
| freq_oor | input | 1 | Out-of-range flag from the precise frequency monitor |
| qualified | output | 1 | Reference is qualified |
| fail | output | 1 | Any monitor failure, or reference disqualified |
| holdover_req | output | 1 | Immediate holdover request |

## Verification
The bench builds the block with `DISQ_TICKS`=5 and `REQ_TICKS`=8. With these values a full disqualify, requalify, disqualify cycle takes a few dozen clocks, so both counter boundaries can be reached directly. They include the exact tick on which each limit is crossed, a clean run broken one tick short of the limit, and bursts split by long clean gaps. Because the clean limit is larger than the disruption limit, a test can run a clean gap longer than the requalify interval while the reference is still qualified. This shows that such a gap does not clear the accumulator.

// File: rtl/ref_qual_pkg.sv
// Shared types for the reference qualification timer.
package ref_qual_pkg;
    // Qualification verdict held by the state register.
    typedef enum logic {
        QS_DISQ = 1'b0,
        QS_QUAL = 1'b1
    } qual_state_t;
endpackage

// File: rtl/ref_disrupt_accum.sv
// Accumulates ticks that see disruption. The count saturates at LIMIT and is
// cleared only by the clear input. Assumes tick_en is a single-cycle strobe.
// hit pulses on the tick that brings the count up to LIMIT.
module ref_disrupt_accum #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic disrupt,
    input  logic clear,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] FULL = W'(LIMIT);

    logic [W-1:0] acc_q;
    logic         bump;

    // Count only disrupted ticks, and stop counting at the limit.
    assign bump = tick_en && disrupt && (acc_q != FULL);
    assign hit  = tick_en && disrupt && (acc_q == LAST);

    // Accumulator register, cleared by reset or by requalification.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (bump) begin
            acc_q <= acc_q + 1'b1;
        end
    end
endmodule

// File: rtl/ref_clean_timer.sv
// Counts consecutive clean ticks while armed. Any cycle with disruption,
// or being disarmed, restarts the run. done pulses on the LIMIT-th clean
// tick. Assumes tick_en is a single-cycle strobe.
module ref_clean_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic disrupt,
    input  logic arm,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] run_q;

    // The run ends on its final clean tick.
    assign done = arm && tick_en && !disrupt && (run_q == LAST);

    // Clean-run counter with restart on disruption or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || disrupt || done) begin
            run_q <= '0;
        end else if (tick_en) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/ref_qual_state.sv
// Holds the qualification verdict. It drops on a disqualify hit and rises
// when the clean run is done. Assumes hit is only acted on while qualified
// and done only while disqualified.
module ref_qual_state
    import ref_qual_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit,
    input  logic        done,
    output qual_state_t state
);
    // Verdict register; reset leaves the reference disqualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= QS_DISQ;
        end else begin
            case (state)
                QS_QUAL: if (hit)  state <= QS_DISQ;
                default: if (done) state <= QS_QUAL;
            endcase
        end
    end
endmodule

// File: rtl/ref_qual_timer.sv
// Top of the reference qualification timer. It disqualifies a reference
// after DISQ_TICKS accumulated disrupted ticks, and requalifies it after
// REQ_TICKS consecutive clean ticks. Holdover is requested at once while
// disruption is present. Assumes synchronous inputs and a one-cycle tick_en.
module ref_qual_timer
    import ref_qual_pkg::*;
#(
    parameter int DISQ_TICKS = 2500,
    parameter int REQ_TICKS  = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic disrupt,
    input  logic freq_oor,
    output logic qualified,
    output logic fail,
    output logic holdover_req
);
    qual_state_t state;
    logic        hit;
    logic        done;
    logic        is_qual;

    assign is_qual = (state == QS_QUAL);

    ref_disrupt_accum #(.LIMIT(DISQ_TICKS)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .disrupt (disrupt),
        .clear   (done),
        .hit     (hit)
    );

    ref_clean_timer #(.LIMIT(REQ_TICKS)) u_clean (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .disrupt (disrupt),
        .arm     (!is_qual),
        .done    (done)
    );

    ref_qual_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit && is_qual),
        .done  (done),
        .state (state)
    );

    // Output combination: monitor verdicts plus the timer verdict.
    assign qualified    = is_qual;
    assign holdover_req = disrupt;
    assign fail         = disrupt || freq_oor || !is_qual;
endmodule

// File: rtl/ref_qual_timer_chk.sv
// Protocol checks for ref_qual_timer, attached through bind.
module ref_qual_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic disrupt,
    input logic freq_oor,
    input logic qualified,
    input logic fail
);
    // R6
    rise_on_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(tick_en && !disrupt));

    // R4
    fall_on_disrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(qualified) |-> $past(tick_en && disrupt));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(qualified));

    // R3
    disq_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qualified |-> fail);

    // R2
    oor_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_oor |-> fail);
endmodule

bind ref_qual_timer ref_qual_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .disrupt   (disrupt),
    .freq_oor  (freq_oor),
    .qualified (qualified),
    .fail      (fail)
);

// File: tb/ref_qual_timer_bench.sv
module ref_qual_timer_bench;
    localparam int DISQ = 5;
    localparam int REQ  = 8;
    localparam int NSEG = 14;

    // Segment table: {tick_en, disrupt, freq_oor}, length, expected qualified.
    localparam logic [2:0] STIM [NSEG] = '{
        3'b100, 3'b110, 3'b100, 3'b100, 3'b001, 3'b110, 3'b100,
        3'b010, 3'b110, 3'b100, 3'b110, 3'b100, 3'b110, 3'b110};
    localparam int LEN [NSEG] = '{7, 1, 7, 1, 3, 3, 7, 4, 1, 20, 1, 8, 4, 1};
    localparam logic EXPQ [NSEG] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 0};
    // Requirement each segment ends on (R7 restart, R6 requal, R2 oor, R5 gaps,
    // R10 no-tick, R4 limit, R8 cleared accumulator).
    localparam int TAG [NSEG] = '{6, 7, 7, 6, 2, 5, 5, 10, 5, 5, 4, 6, 8, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic disrupt = 1'b0;
    logic freq_oor = 1'b0;
    logic qualified, fail, holdover_req;
    int   checks = 0;
    int   errors = 0;

    always #5 clk = ~clk;

    ref_qual_timer #(.DISQ_TICKS(DISQ), .REQ_TICKS(REQ)) u_ref_qual_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .disrupt      (disrupt),
        .freq_oor     (freq_oor),
        .qualified    (qualified),
        .fail         (fail),
        .holdover_req (holdover_req)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample after it.
    task automatic step(input logic t, input logic d, input logic o);
        @(negedge clk);
        tick_en = t; disrupt = d; freq_oor = o;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R9", "qualified in reset", qualified, 1'b0);
        check("R9", "fail in reset", fail, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < NSEG; s++) begin
            for (int n = 0; n < LEN[s]; n++) begin
                step(STIM[s][2], STIM[s][1], STIM[s][0]);
                // R1: holdover follows disrupt
                check("R1", "holdover_req", holdover_req, STIM[s][1]);
            end
            check($sformatf("R%0d", TAG[s]), $sformatf("qualified seg %0d", s),
                  qualified, EXPQ[s]);
            // R3: fail combination
            check("R3", $sformatf("fail seg %0d", s), fail,
                  STIM[s][1] | STIM[s][0] | ~EXPQ[s]);
        end

        // R1: combinational holdover before any edge, tick low
        @(negedge clk);
        tick_en = 1'b0; disrupt = 1'b1; freq_oor = 1'b0;
        #1;
        check("R1", "holdover before edge", holdover_req, 1'b1);
        // R2: out-of-range alone gives fail but no holdover
        disrupt = 1'b0; freq_oor = 1'b1;
        #1;
        check("R2", "holdover with oor", holdover_req, 1'b0);
        check("R2", "fail with oor", fail, 1'b1);

        // R7: a non-tick disruption mid-run restarts the clean run
        for (int n = 0; n < REQ - 1; n++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R7", "no requal after non-tick hit", qualified, 1'b0);
        for (int n = 0; n < REQ - 2; n++) step(1'b1, 1'b0, 1'b0);
        check("R7", "one tick short", qualified, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R6", "requal after full run", qualified, 1'b1);

        // R9: reset while qualified returns to disqualified
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; disrupt = 1'b0; freq_oor = 1'b0;
        @(posedge clk);
        #2;
        check("R9", "qualified after mid reset", qualified, 1'b0);
        check("R9", "fail after mid reset", fail, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule